// File: doc/BRIEF.md
# Pad Hit Digitizer with Coarse Timestamp

This block is the digital back end of a 64-pad readout chip. Each pad arrives as a single discriminator bit, already compared against one threshold that all pads share. The block holds that threshold value in a register and drives it out to the analog side. It also keeps a free-running timestamp counter that advances once per 100 ns timing strobe.

The block captures the 64 pad bits as one hit pattern in either of two modes. In triggered mode it captures only in a cycle where the trigger input is high, and it captures even when no pad is hit. In self-triggered mode it captures in any cycle where at least one pad is hit.

Each capture becomes one record: the timestamp, the chip's address and the pattern. Records wait in a small FIFO and leave on a valid/ready handshake, in the order they were captured. A capture that finds the FIFO full is discarded and counted.

Top module: `hit_stamper`

## Requirements
- R1: After reset, `rec_valid` is 0, `drop_count` is 0, `thr_value` is 0 and the timestamp counter is 0.
- R2: The timestamp counter rises by one at each clock edge where `ts_tick` is 1 and holds otherwise. A capture stores the counter value present in its capture cycle, before that edge updates the counter.
- R3: `ts_clear` zeroes the timestamp counter at the next edge and takes priority over `ts_tick`. After the all-ones value, a tick wraps the counter to 0 with no other effect.
- R4: With `mode_self` = 0 (triggered mode), a capture happens exactly in the cycles where `trig_in` is 1. Pad hits without a trigger produce no record.
- R5: In triggered mode, a trigger in a cycle with no pad hit still produces a record whose pattern is all zeros.
- R6: With `mode_self` = 1 (self-triggered mode), a capture happens in every cycle with at least one bit of `pad_hit` set. `trig_in` is ignored, and a cycle with no hit produces no record.
- R7: The record layout is: timestamp in the top TS_W bits, `chip_addr` in the next ADDR_W bits, and the pattern in the low PADS bits, with pad i at bit i.
- R8: A record is offered on `rec_data` with `rec_valid` high from the cycle after its capture edge, when the FIFO was empty. Records leave in capture order, one per edge with `rec_valid` and `rec_ready` both high. `rec_data` holds steady while `rec_valid` is high and `rec_ready` is low.
- R9: A capture is dropped when the FIFO already holds FIFO_DEPTH records before the edge, even if a record leaves at that same edge. Each drop raises `drop_count` by one, and the count saturates at its all-ones value.
- R10: `thr_value` takes `thr_wr_data` at an edge where `thr_wr_en` is 1 and holds otherwise. It has no effect on capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ts_tick | input | 1 | One-cycle strobe every 100 ns; advances the timestamp |
| ts_clear | input | 1 | Synchronous timestamp counter clear |
| mode_self | input | 1 | 0 = triggered capture, 1 = self-triggered capture |
| trig_in | input | 1 | Capture trigger in triggered mode |
| pad_hit | input | PADS (64) | Discriminator outputs, pad i on bit i |
| chip_addr | input | ADDR_W (16) | Address placed in every record |
| thr_wr_en | input | 1 | Threshold register write strobe |
| thr_wr_data | input | THR_W (8) | New threshold value |
| thr_value | output | THR_W (8) | Held shared threshold, to the analog side |
| rec_valid | output | 1 | A record is offered |
| rec_ready | input | 1 | Consumer accepts the offered record |
| rec_data | output | TS_W+ADDR_W+PADS (104) | Record: timestamp, address, pattern |
| drop_count | output | DROP_W (8) | Saturating count of dropped captures |

## Verification
The bench builds the block with TS_W = 10 and DROP_W = 3, and keeps 64 pads, a 16-bit address and a four-deep FIFO. The narrow timestamp lets the counter wrap after 1024 ticks, so the wrap can be checked within the run. The 3-bit drop counter reaches saturation at 7 after a short burst of captures into a full FIFO. Random pad patterns, triggers, ticks, clears and ready stalls are mixed with directed cases: a zero-pattern trigger, triggers ignored in self-triggered mode, hits ignored without a trigger, a full-FIFO push coinciding with a pop, and the wrap.

// File: rtl/hit_stamp_pkg.sv
package hit_stamp_pkg;

    // Capture mode selection
    typedef enum logic {
        CAP_TRIGGERED = 1'b0,
        CAP_SELF      = 1'b1
    } cap_mode_e;

    localparam int DEF_PADS   = 64;
    localparam int DEF_TS_W   = 24;
    localparam int DEF_ADDR_W = 16;
    localparam int DEF_THR_W  = 8;
    localparam int DEF_DEPTH  = 4;
    localparam int DEF_DROP_W = 8;

    // FIFO operation for one cycle
    typedef struct packed {
        logic accept;
        logic pop;
        logic drop;
    } fifo_op_t;

    // Circular index advance
    function automatic int unsigned ring_next(int unsigned idx, int unsigned depth);
        return (idx == depth - 1) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/hs_timebase.sv
module hs_timebase #(
    parameter int TS_W = 24
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    input  logic            clear,
    output logic [TS_W-1:0] ts
);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            ts <= '0;
        end else if (tick) begin
            ts <= ts + 1'b1;
        end
    end

endmodule

// File: rtl/hs_capture.sv
module hs_capture
    import hit_stamp_pkg::*;
#(
    parameter int PADS   = 64,
    parameter int TS_W   = 24,
    parameter int ADDR_W = 16,
    localparam int REC_W = TS_W + ADDR_W + PADS
) (
    input  logic              mode_self,
    input  logic              trig_in,
    input  logic [PADS-1:0]   pad_hit,
    input  logic [TS_W-1:0]   ts,
    input  logic [ADDR_W-1:0] addr,
    output logic              fire,
    output logic [REC_W-1:0]  rec
);

    cap_mode_e mode;

    always_comb begin
        mode = cap_mode_e'(mode_self);
        unique case (mode)
            CAP_SELF:      fire = |pad_hit;
            CAP_TRIGGERED: fire = trig_in;
            default:       fire = 1'b0;
        endcase
        rec = {ts, addr, pad_hit};
    end

endmodule

// File: rtl/hs_fifo.sv
module hs_fifo
    import hit_stamp_pkg::*;
#(
    parameter int W      = 104,
    parameter int DEPTH  = 4,
    parameter int DROP_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [W-1:0]      din,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [W-1:0]      dout,
    output logic [DROP_W-1:0] drop_cnt
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          full;
    fifo_op_t      op;

    always_comb begin
        full      = (count == CW'(DEPTH));
        out_valid = (count != '0);
        op.pop    = out_valid && out_ready;
        op.accept = push && !full;
        op.drop   = push && full;
        dout      = mem[rd_ptr];
    end

    always_ff @(posedge clk) begin
        if (op.accept) begin
            mem[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            count    <= '0;
            drop_cnt <= '0;
        end else begin
            if (op.accept) begin
                wr_ptr <= PW'(ring_next(int'(wr_ptr), DEPTH));
            end
            if (op.pop) begin
                rd_ptr <= PW'(ring_next(int'(rd_ptr), DEPTH));
            end
            case ({op.accept, op.pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
            if (op.drop && (drop_cnt != '1)) begin
                drop_cnt <= drop_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/hit_stamper.sv
module hit_stamper
    import hit_stamp_pkg::*;
#(
    parameter int PADS       = DEF_PADS,
    parameter int TS_W       = DEF_TS_W,
    parameter int ADDR_W     = DEF_ADDR_W,
    parameter int THR_W      = DEF_THR_W,
    parameter int FIFO_DEPTH = DEF_DEPTH,
    parameter int DROP_W     = DEF_DROP_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       ts_tick,
    input  logic                       ts_clear,
    input  logic                       mode_self,
    input  logic                       trig_in,
    input  logic [PADS-1:0]            pad_hit,
    input  logic [ADDR_W-1:0]          chip_addr,
    input  logic                       thr_wr_en,
    input  logic [THR_W-1:0]           thr_wr_data,
    output logic [THR_W-1:0]           thr_value,
    output logic                       rec_valid,
    input  logic                       rec_ready,
    output logic [TS_W+ADDR_W+PADS-1:0] rec_data,
    output logic [DROP_W-1:0]          drop_count
);

    localparam int REC_W = TS_W + ADDR_W + PADS;

    logic [TS_W-1:0]  ts_now;
    logic             cap_fire;
    logic [REC_W-1:0] cap_rec;

    // Shared threshold register
    always_ff @(posedge clk) begin
        if (rst) begin
            thr_value <= '0;
        end else if (thr_wr_en) begin
            thr_value <= thr_wr_data;
        end
    end

    hs_timebase #(.TS_W(TS_W)) u_timebase (
        .clk   (clk),
        .rst   (rst),
        .tick  (ts_tick),
        .clear (ts_clear),
        .ts    (ts_now)
    );

    hs_capture #(.PADS(PADS), .TS_W(TS_W), .ADDR_W(ADDR_W)) u_capture (
        .mode_self (mode_self),
        .trig_in   (trig_in),
        .pad_hit   (pad_hit),
        .ts        (ts_now),
        .addr      (chip_addr),
        .fire      (cap_fire),
        .rec       (cap_rec)
    );

    hs_fifo #(.W(REC_W), .DEPTH(FIFO_DEPTH), .DROP_W(DROP_W)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (cap_fire),
        .din       (cap_rec),
        .out_valid (rec_valid),
        .out_ready (rec_ready),
        .dout      (rec_data),
        .drop_cnt  (drop_count)
    );

endmodule

// File: rtl/hit_stamper_chk.sv
module hit_stamper_chk #(
    parameter int PADS   = 64,
    parameter int TS_W   = 24,
    parameter int ADDR_W = 16,
    parameter int THR_W  = 8,
    parameter int DROP_W = 8,
    localparam int REC_W = TS_W + ADDR_W + PADS
) (
    input logic              clk,
    input logic              rst,
    input logic              ts_tick,
    input logic              ts_clear,
    input logic              mode_self,
    input logic              trig_in,
    input logic [PADS-1:0]   pad_hit,
    input logic              thr_wr_en,
    input logic [THR_W-1:0]  thr_wr_data,
    input logic [THR_W-1:0]  thr_value,
    input logic              rec_valid,
    input logic              rec_ready,
    input logic [REC_W-1:0]  rec_data,
    input logic [DROP_W-1:0] drop_count,
    input logic [TS_W-1:0]   ts_now
);

    // R1: reset empties the queue and clears the drop count and threshold
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (!rec_valid && drop_count == '0 && thr_value == '0 && ts_now == '0));

    // R2: a tick without clear advances the counter by one
    a_r2_tick_step: assert property (@(posedge clk) disable iff (rst)
        (ts_tick && !ts_clear) |=> (ts_now == TS_W'($past(ts_now) + 1'b1)));

    // R3: clear wins over tick
    a_r3_clear_zero: assert property (@(posedge clk) disable iff (rst)
        ts_clear |=> (ts_now == '0));

    // R4: no trigger in triggered mode with an empty queue leaves it empty
    a_r4_no_trig_no_rec: assert property (@(posedge clk) disable iff (rst)
        (!mode_self && !trig_in && !rec_valid) |=> !rec_valid);

    // R5: trigger into an empty queue offers the sampled pattern next cycle
    a_r5_trig_pattern: assert property (@(posedge clk) disable iff (rst)
        (!mode_self && trig_in && !rec_valid)
        |=> (rec_valid && rec_data[PADS-1:0] == $past(pad_hit)));

    // R6: no hit in self-triggered mode with an empty queue leaves it empty
    a_r6_no_hit_no_rec: assert property (@(posedge clk) disable iff (rst)
        (mode_self && pad_hit == '0 && !rec_valid) |=> !rec_valid);

    // R8: an offered record is held until taken
    a_r8_hold_stall: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && !rec_ready) |=> (rec_valid && $stable(rec_data)));

    // R9: the drop count never decreases outside reset
    a_r9_drop_monotonic: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (drop_count >= $past(drop_count)));

    // R10: a write loads the threshold
    a_r10_thr_load: assert property (@(posedge clk) disable iff (rst)
        thr_wr_en |=> (thr_value == $past(thr_wr_data)));

    // R10: no write keeps the threshold
    a_r10_thr_hold: assert property (@(posedge clk) disable iff (rst)
        !thr_wr_en |=> $stable(thr_value));

endmodule

bind hit_stamper hit_stamper_chk #(
    .PADS(PADS), .TS_W(TS_W), .ADDR_W(ADDR_W), .THR_W(THR_W), .DROP_W(DROP_W)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .ts_tick     (ts_tick),
    .ts_clear    (ts_clear),
    .mode_self   (mode_self),
    .trig_in     (trig_in),
    .pad_hit     (pad_hit),
    .thr_wr_en   (thr_wr_en),
    .thr_wr_data (thr_wr_data),
    .thr_value   (thr_value),
    .rec_valid   (rec_valid),
    .rec_ready   (rec_ready),
    .rec_data    (rec_data),
    .drop_count  (drop_count),
    .ts_now      (ts_now)
);

// File: tb/hit_stamper_tb_top.sv
`timescale 1ns/1ps
module hit_stamper_tb_top;

    localparam int PADS   = 64;
    localparam int TS_W   = 10;
    localparam int ADDR_W = 16;
    localparam int THR_W  = 8;
    localparam int DEPTH  = 4;
    localparam int DROP_W = 3;
    localparam int REC_W  = TS_W + ADDR_W + PADS;

    logic              clk = 1'b0;
    logic              rst;
    logic              ts_tick, ts_clear, mode_self, trig_in;
    logic [PADS-1:0]   pad_hit;
    logic [ADDR_W-1:0] chip_addr;
    logic              thr_wr_en;
    logic [THR_W-1:0]  thr_wr_data, thr_value;
    logic              rec_valid, rec_ready;
    logic [REC_W-1:0]  rec_data;
    logic [DROP_W-1:0] drop_count;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // Bench model state
    logic [REC_W-1:0]  mq[$];
    logic [TS_W-1:0]   m_ts;
    logic [DROP_W-1:0] m_drop;
    logic [THR_W-1:0]  m_thr;

    always #2 clk = ~clk;

    hit_stamper #(
        .PADS(PADS), .TS_W(TS_W), .ADDR_W(ADDR_W), .THR_W(THR_W),
        .FIFO_DEPTH(DEPTH), .DROP_W(DROP_W)
    ) dut_i (
        .clk(clk), .rst(rst), .ts_tick(ts_tick), .ts_clear(ts_clear),
        .mode_self(mode_self), .trig_in(trig_in), .pad_hit(pad_hit),
        .chip_addr(chip_addr), .thr_wr_en(thr_wr_en), .thr_wr_data(thr_wr_data),
        .thr_value(thr_value), .rec_valid(rec_valid), .rec_ready(rec_ready),
        .rec_data(rec_data), .drop_count(drop_count)
    );

    function automatic logic [REC_W-1:0] mk_rec(logic [TS_W-1:0] t,
                                               logic [ADDR_W-1:0] a,
                                               logic [PADS-1:0] p);
        return {t, a, p};
    endfunction

    task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Apply current inputs for one edge, advance the model, compare outputs
    task automatic step();
        bit fire, full, pop;
        fire = mode_self ? (pad_hit != '0) : trig_in;
        full = (mq.size() == DEPTH);
        pop  = (mq.size() != 0) && rec_ready;
        if (pop) void'(mq.pop_front());
        if (fire) begin
            if (!full) mq.push_back(mk_rec(m_ts, chip_addr, pad_hit));
            else if (m_drop != '1) m_drop++;
        end
        if (thr_wr_en) m_thr = thr_wr_data;
        if (ts_clear) m_ts = '0;
        else if (ts_tick) m_ts = m_ts + 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R8 valid", 128'(rec_valid), 128'(mq.size() != 0));
        if (mq.size() != 0)
            check("R2 R3 R7 R8 record", 128'(rec_data), 128'(mq[0]));
        check("R9 drop_count", 128'(drop_count), 128'(m_drop));
        check("R10 thr_value", 128'(thr_value), 128'(m_thr));
    endtask

    task automatic idle_inputs();
        ts_tick = 0; ts_clear = 0; trig_in = 0; pad_hit = '0;
        thr_wr_en = 0; thr_wr_data = '0; rec_ready = 1;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'd20070204));
        rst = 1; mode_self = 0; chip_addr = 16'hA55A;
        idle_inputs();
        m_ts = '0; m_drop = '0; m_thr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1 reset state
        check("R1 rec_valid", 128'(rec_valid), 128'(0));
        check("R1 drop_count", 128'(drop_count), 128'(0));
        check("R1 thr_value", 128'(thr_value), 128'(0));

        // R1 R5: first trigger with no hits stamps 0 and zero pattern
        trig_in = 1; rec_ready = 0; step();
        check("R1 R5 first record", 128'(rec_data), 128'(mk_rec('0, chip_addr, '0)));
        trig_in = 0; rec_ready = 1; step();

        // R4: hits without trigger in triggered mode
        pad_hit = 64'hFFFF_0000_1234_8001;
        repeat (5) step();
        check("R4 no record", 128'(rec_valid), 128'(0));

        // R6: triggers ignored in self mode, no hit
        mode_self = 1; pad_hit = '0; trig_in = 1;
        repeat (5) step();
        check("R6 trig ignored", 128'(rec_valid), 128'(0));
        // R6 R7: single pad hit, pad 37
        trig_in = 0; pad_hit = 64'd1 << 37; rec_ready = 0; step();
        check("R6 R7 pad 37", 128'(rec_data[PADS-1:0]), 128'(64'd1 << 37));
        pad_hit = '0; rec_ready = 1; repeat (2) step();

        // R9: fill, then push while full and popping at once, then saturate
        pad_hit = 64'h8000_0000_0000_0000; rec_ready = 0;
        repeat (DEPTH) step();
        rec_ready = 1; step();
        check("R9 drop with pop", 128'(drop_count), 128'(1));
        rec_ready = 0;
        repeat (12) step();
        check("R9 saturated", 128'(drop_count), 128'((1 << DROP_W) - 1));
        pad_hit = '0; rec_ready = 1; repeat (DEPTH + 1) step();

        // R10: threshold write
        thr_wr_en = 1; thr_wr_data = 8'hC3; step();
        thr_wr_en = 0; thr_wr_data = 8'h11; step();
        check("R10 held", 128'(thr_value), 128'(8'hC3));

        // R3: clear with tick, then wrap through all-ones
        ts_clear = 1; ts_tick = 1; step();
        ts_clear = 0;
        repeat (1 << TS_W) step();
        ts_tick = 0; mode_self = 0; trig_in = 1; rec_ready = 0; step();
        check("R3 wrapped stamp", 128'(rec_data[REC_W-1 -: TS_W]), 128'(0));
        trig_in = 0; rec_ready = 1; repeat (2) step();

        // Random mix (R2 R4 R6 R8 R9 via model)
        for (int seg = 0; seg < 40; seg++) begin
            mode_self = $urandom_range(0, 1);
            chip_addr = 16'($urandom);
            for (int c = 0; c < 150; c++) begin
                ts_tick   = ($urandom_range(0, 3) == 0);
                ts_clear  = ($urandom_range(0, 199) == 0);
                trig_in   = ($urandom_range(0, 4) == 0);
                pad_hit   = ($urandom_range(0, 2) == 0)
                            ? {32'($urandom), 32'($urandom)} : '0;
                rec_ready = (seg % 4 == 3) ? ($urandom_range(0, 5) == 0)
                                           : ($urandom_range(0, 1) == 1);
                thr_wr_en = ($urandom_range(0, 19) == 0);
                thr_wr_data = 8'($urandom);
                step();
            end
        end
        idle_inputs(); repeat (DEPTH + 2) step();
        check("R8 drained", 128'(rec_valid), 128'(0));

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule